// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes stack-machine instructions handed to it one at a time over a valid/ready handshake. It keeps an internal operand stack. Only the two data-moving instructions carry a memory address. A load-to-stack instruction reads a word from data memory and places it on top of the stack. A store-from-stack instruction removes the top entry and writes it to memory. The add, subtract and multiply instructions take both operands from the stack and leave a single result in their place.

Data memory is reached through a simple synchronous port. A read request returns its data in the cycle after the request. A write takes effect at the edge that ends its request cycle. Two sticky flags report stack overflow and stack underflow. An instruction that would overflow or underflow the stack is consumed without touching the stack or memory.

The controller is a four-state machine:
- `S_IDLE` accepts instructions.
- `S_RDREQ` drives the read request.
- `S_RDWAIT` captures the returned word onto the stack.
- `S_WRITE` drives the write request and removes the top entry.

Its transitions are:
- `S_IDLE` to `S_RDREQ` on an accepted push that fits.
- `S_IDLE` to `S_WRITE` on an accepted pop with a non-empty stack.
- `S_RDREQ` to `S_RDWAIT`, unconditionally.
- `S_RDWAIT` to `S_IDLE`, unconditionally.
- `S_WRITE` to `S_IDLE`, unconditionally.

Every other case stays in `S_IDLE`. The ready output is high only in `S_IDLE`.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset, instr_ready is 1, mem_req is 0, both error flags are 0 and the stack is empty.
- R2: A push (opcode 0) accepted with fewer than DEPTH entries produces a read request (mem_req=1, mem_we=0) at its address in the next cycle. The returned word becomes the new top one cycle later. instr_ready is 0 during both of those cycles.
- R3: A pop (opcode 1) accepted on a non-empty stack produces, in the next cycle, a write request (mem_req=1, mem_we=1) at its address carrying the top entry, and removes that entry. instr_ready is 0 during that cycle.
- R4: Add (opcode 2) on a stack of two or more entries replaces the top two entries with their sum in one cycle, with no memory access and instr_ready staying 1.
- R5: Sub (opcode 3) replaces the top two entries with (top minus the entry beneath it).
- R6: Mult (opcode 4) replaces the top two entries with the low DW bits of their product.
- R7: A push to a full stack sets err_overflow, makes no memory access and leaves the stack contents unchanged.
- R8: A pop on an empty stack, or an add/sub/mult with fewer than two entries, sets err_underflow, makes no memory access and leaves the stack contents unchanged.
- R9: Opcodes 5, 6 and 7 are accepted and have no effect on the stack, memory or flags.
- R10: The sequence push E, push C, push D, mult, push B, add, sub, push F, add, push A, add, pop A stores B+C*D-E+F+A at A.
- R11: Once set, each error flag stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit can take an instruction |
| instr_op | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 sub, 4 mult |
| instr_addr | input | AW | Memory address for push and pop |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |
| err_overflow | output | 1 | Sticky stack overflow flag |
| err_underflow | output | 1 | Sticky stack underflow flag |

## Verification
The embedded properties check the following on every cycle:
- the read and write requests that follow an accepted push or pop, including the address and write data,
- the absence of memory traffic for folded arithmetic,
- the one-entry drop of a fold,
- the unchanged stack on a held cycle,
- the bound on stack depth,
- the stickiness of the error flags.

The arithmetic results themselves, the operand order of subtraction, truncation of products, and the full expression sequence can only be shown by the bench's scenarios. In those scenarios a behavioural model tracks the stack and handshake each clock, and the final memory contents are compared against computed values.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_MULT = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_PUSH,
        ACT_POP,
        ACT_FOLD
    } act_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RDREQ,
        S_RDWAIT,
        S_WRITE
    } state_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
    parameter int DW = 16
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] first,
    input  logic [DW-1:0] second,
    output logic [DW-1:0] result
);
    import stk_pkg::*;

    always_comb begin
        result = '0;
        case (op)
            OP_ADD:  result = first + second;
            OP_SUB:  result = first - second;   // first popped is left operand
            OP_MULT: result = first * second;   // low DW bits kept
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/stk_store.sv
module stk_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  stk_pkg::act_e              act,
    input  logic [DW-1:0]              din,
    output logic [DW-1:0]              tos,
    output logic [DW-1:0]              nos,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    import stk_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 2) ? $clog2(DEPTH - 1) : 1;

    logic [DW-1:0] below [DEPTH-1];
    logic [DW-1:0] tos_q;
    logic [CW-1:0] cnt_q;

    assign tos   = tos_q;
    assign count = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign nos   = (cnt_q >= CW'(2)) ? below[IW'(cnt_q - CW'(2))] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_PUSH: begin
                    tos_q <= din;
                    cnt_q <= cnt_q + CW'(1);
                end
                ACT_POP: begin
                    tos_q <= nos;
                    cnt_q <= cnt_q - CW'(1);
                end
                ACT_FOLD: begin
                    tos_q <= din;
                    cnt_q <= cnt_q - CW'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (act == ACT_PUSH && cnt_q != '0)
            below[IW'(cnt_q - CW'(1))] <= tos_q;
    end

    // R7: depth never passes the capacity
    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R4: a fold removes exactly one entry
    a_r4_fold_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_FOLD |=> cnt_q == $past(cnt_q) - CW'(1));

    // R8: a held cycle leaves the stack untouched
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_HOLD |=> ($stable(cnt_q) && $stable(tos_q)));
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
    parameter int DW    = 16,
    parameter int AW    = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       instr_valid,
    output logic                       instr_ready,
    input  logic [2:0]                 instr_op,
    input  logic [AW-1:0]              instr_addr,
    input  logic [DW-1:0]              tos,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       full,
    input  logic                       empty,
    output stk_pkg::act_e              act,
    output logic                       take_mem,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic                       err_overflow,
    output logic                       err_underflow
);
    import stk_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    state_e        state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          ovf_q, unf_q;
    logic          set_ovf, set_unf, latch_addr;
    logic          accept;

    assign accept = instr_valid && (state_q == S_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        act         = ACT_HOLD;
        take_mem    = 1'b0;
        set_ovf     = 1'b0;
        set_unf     = 1'b0;
        latch_addr  = 1'b0;
        instr_ready = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                instr_ready = 1'b1;
                if (instr_valid) begin
                    case (instr_op)
                        OP_PUSH: begin
                            if (full) set_ovf = 1'b1;
                            else begin
                                latch_addr = 1'b1;
                                state_d    = S_RDREQ;
                            end
                        end
                        OP_POP: begin
                            if (empty) set_unf = 1'b1;
                            else begin
                                latch_addr = 1'b1;
                                state_d    = S_WRITE;
                            end
                        end
                        OP_ADD, OP_SUB, OP_MULT: begin
                            if (count < CW'(2)) set_unf = 1'b1;
                            else                act     = ACT_FOLD;
                        end
                        default: ;
                    endcase
                end
            end
            S_RDREQ: begin
                mem_req = 1'b1;
                state_d = S_RDWAIT;
            end
            S_RDWAIT: begin
                act      = ACT_PUSH;
                take_mem = 1'b1;
                state_d  = S_IDLE;
            end
            S_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                act     = ACT_POP;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            if (latch_addr) addr_q <= instr_addr;
            if (set_ovf)    ovf_q  <= 1'b1;
            if (set_unf)    unf_q  <= 1'b1;
        end
    end

    assign mem_addr      = addr_q;
    assign err_overflow  = ovf_q;
    assign err_underflow = unf_q;

    // R2: an accepted push that fits issues a read at its address next cycle
    a_r2_read_follows_push: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && instr_op == OP_PUSH && !full) |=>
        (mem_req && !mem_we && mem_addr == $past(instr_addr) && !instr_ready));

    // R3: an accepted pop issues a write of the old top at its address
    a_r3_write_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && instr_op == OP_POP && !empty) |=>
        (mem_req && mem_we && mem_addr == $past(instr_addr) && tos == $past(tos)));

    // R4: folded arithmetic stays off the memory port and keeps ready high
    a_r4_fold_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (instr_op == OP_ADD || instr_op == OP_SUB || instr_op == OP_MULT)) |=>
        (!mem_req && instr_ready));

    // R11: error flags are sticky
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    a_r11_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |=> unf_q);
endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit #(
    parameter int DW    = 16,
    parameter int AW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    output logic          instr_ready,
    input  logic [2:0]    instr_op,
    input  logic [AW-1:0] instr_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          err_overflow,
    output logic          err_underflow
);
    import stk_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    act_e          act;
    logic          take_mem;
    logic [DW-1:0] tos, nos, alu_res, din;
    logic [CW-1:0] count;
    logic          full, empty;

    stk_ctrl #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .instr_ready   (instr_ready),
        .instr_op      (instr_op),
        .instr_addr    (instr_addr),
        .tos           (tos),
        .count         (count),
        .full          (full),
        .empty         (empty),
        .act           (act),
        .take_mem      (take_mem),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .err_overflow  (err_overflow),
        .err_underflow (err_underflow)
    );

    stk_alu #(.DW(DW)) u_alu (
        .op     (instr_op),
        .first  (tos),
        .second (nos),
        .result (alu_res)
    );

    assign din       = take_mem ? mem_rdata : alu_res;
    assign mem_wdata = tos;

    stk_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .din   (din),
        .tos   (tos),
        .nos   (nos),
        .count (count),
        .full  (full),
        .empty (empty)
    );
endmodule

// File: tb/stack_exec_unit_bench.sv
`timescale 1ns/1ps
module stack_exec_unit_bench;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic          instr_ready;
    logic [2:0]    instr_op = '0;
    logic [AW-1:0] instr_addr = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          err_overflow, err_underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stack_exec_unit #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_stack_exec_unit (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_op(instr_op), .instr_addr(instr_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    // bench data memory
    logic [DW-1:0] mem_arr [256];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem_arr[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem_arr[mem_addr];
        end
    end

    // behavioural reference model
    logic [DW-1:0] m_stk[$];
    int            m_phase = 0;   // 0 idle, 1 read req, 2 read wait, 3 write
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic          m_ovf = 1'b0, m_unf = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stk.delete();
            m_phase = 0; m_ovf = 1'b0; m_unf = 1'b0;
        end else begin
            case (m_phase)
                0: if (instr_valid) begin
                    case (instr_op)
                        3'd0: if (m_stk.size() == DEPTH) m_ovf = 1'b1;
                              else begin m_phase = 1; m_addr = instr_addr; end
                        3'd1: if (m_stk.size() == 0) m_unf = 1'b1;
                              else begin
                                  m_phase = 3; m_addr = instr_addr;
                                  m_wdata = m_stk.pop_back();
                              end
                        3'd2, 3'd3, 3'd4: if (m_stk.size() < 2) m_unf = 1'b1;
                              else begin
                                  logic [DW-1:0] a, b, r;
                                  a = m_stk.pop_back();
                                  b = m_stk.pop_back();
                                  if (instr_op == 3'd2)      r = a + b;
                                  else if (instr_op == 3'd3) r = a - b;
                                  else                       r = DW'(int'(a) * int'(b));
                                  m_stk.push_back(r);
                              end
                        default: ;
                    endcase
                end
                1: m_phase = 2;
                2: begin m_stk.push_back(mem_arr[m_addr]); m_phase = 0; end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 instr_ready", DW'(instr_ready), DW'(m_phase == 0));
            check("R3 mem_req", DW'(mem_req), DW'(m_phase == 1 || m_phase == 3));
            check("R3 mem_we", DW'(mem_we), DW'(m_phase == 3));
            if (m_phase == 1 || m_phase == 3) check("R2 mem_addr", DW'(mem_addr), DW'(m_addr));
            if (m_phase == 3) check("R3 mem_wdata", mem_wdata, m_wdata);
            check("R7 err_overflow", DW'(err_overflow), DW'(m_ovf));
            check("R8 err_underflow", DW'(err_underflow), DW'(m_unf));
        end
    end

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] addr);
        @(negedge clk);
        instr_valid = 1'b1; instr_op = op; instr_addr = addr;
        while (!instr_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_arr[i] = DW'(i) ^ 16'hAAAA;
        mem_arr[1] = 16'd3;  mem_arr[2] = 16'd5;  mem_arr[3] = 16'd7;   // B C D
        mem_arr[4] = 16'd4;  mem_arr[5] = 16'd10; mem_arr[6] = 16'd2;   // E F A
        mem_arr[10] = 16'd10; mem_arr[11] = 16'd3;
        mem_arr[12] = 16'h1234; mem_arr[13] = 16'h0100;
        mem_arr[14] = 16'd1; mem_arr[15] = 16'd9;
        for (int i = 0; i < 9; i++) mem_arr[40+i] = DW'(100 + i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 ready at reset", DW'(instr_ready), 16'd1);
        check("R1 mem_req at reset", DW'(mem_req), 16'd0);
        check("R1 flags at reset", DW'({err_overflow, err_underflow}), 16'd0);
        rst_n = 1'b1;

        // R10: A = B + C*D - E + F + A
        issue(3'd0, 8'd4); issue(3'd0, 8'd2); issue(3'd0, 8'd3); issue(3'd4, 8'd0);
        issue(3'd0, 8'd1); issue(3'd2, 8'd0); issue(3'd3, 8'd0);
        issue(3'd0, 8'd5); issue(3'd2, 8'd0); issue(3'd0, 8'd6); issue(3'd2, 8'd0);
        issue(3'd1, 8'd6);
        settle();
        check("R10 expression result", mem_arr[6], DW'(3 + 5*7 - 4 + 10 + 2));

        // R5: top minus the entry beneath: 3 - 10
        issue(3'd0, 8'd10); issue(3'd0, 8'd11); issue(3'd3, 8'd0); issue(3'd1, 8'd20);
        settle();
        check("R5 sub order", mem_arr[20], 16'hFFF9);

        // R4 sum
        issue(3'd0, 8'd10); issue(3'd0, 8'd11); issue(3'd2, 8'd0); issue(3'd1, 8'd23);
        settle();
        check("R4 add", mem_arr[23], 16'd13);

        // R6 truncated product 0x1234*0x0100
        issue(3'd0, 8'd12); issue(3'd0, 8'd13); issue(3'd4, 8'd0); issue(3'd1, 8'd21);
        settle();
        check("R6 mult low bits", mem_arr[21], 16'h3400);

        // R8 underflow on empty pop, then arith with one entry
        issue(3'd1, 8'd30);
        settle();
        check("R8 empty pop flag", DW'(err_underflow), 16'd1);
        check("R8 empty pop no write", mem_arr[30], 16'd30 ^ 16'hAAAA);
        issue(3'd0, 8'd14); issue(3'd2, 8'd0); issue(3'd1, 8'd31);
        settle();
        check("R8 stack kept after add underflow", mem_arr[31], 16'd1);

        // R9 unused opcode has no effect
        issue(3'd0, 8'd15); issue(3'd5, 8'd0); issue(3'd7, 8'd0); issue(3'd1, 8'd32);
        settle();
        check("R9 unused opcode ignored", mem_arr[32], 16'd9);

        // R7 overflow
        for (int i = 0; i < 9; i++) issue(3'd0, AW'(40 + i));
        settle();
        check("R7 overflow flag", DW'(err_overflow), 16'd1);
        for (int i = 0; i < 8; i++) issue(3'd1, AW'(60 + i));
        settle();
        check("R7 top kept after overflow", mem_arr[60], 16'd107);
        check("R7 bottom kept after overflow", mem_arr[67], 16'd100);
        check("R11 overflow sticky", DW'(err_overflow), 16'd1);
        check("R11 underflow sticky", DW'(err_underflow), 16'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule